// File: doc/BRIEF.md
# Serial Bus Master Transmit Word Engine

This block is the data-phase engine of a two-wire serial bus interface acting as master transmitter. Software programs a word length and an acknowledge-enable flag in a control register, then writes the transmit word. That write sets a pending flag. The pending flag lets the engine clock SCL and shift the word out on SDA, most significant bit first. If acknowledge is enabled, one more clock follows with SDA released, and the receiver's acknowledge level is captured as the last-received-bit status.

When the word is done, the pending flag drops and a transfer-complete interrupt rises. SCL is then held low, which stretches the bus, until software writes the next word. On the interrupt, software reads the master and transmit status bits, which are both fixed at 1 in this engine. If the last received bit is 1, the receiver wants no more data and software must end the transfer with a stop condition. Start and stop generation are not part of this block. The engine assumes a start condition has already left SCL low.

Top module: `i2c_tx_word_engine`

## Requirements
- R1: After reset: scl_o is 0, sda_o is 1, pending_o, irq_o, overrun_o and last_rx_bit_o are 0, and master_o and xmit_o are 1.
- R2: A data write while pending_o is 0 is accepted on that clock edge. On the next cycle pending_o is 1, irq_o is 0 and overrun_o is 0.
- R3: The control length code sets the number of data bits. Code 0 means 8 bits, and codes 1 to 7 mean that many bits. The engine gives exactly that many data SCL pulses.
- R4: Data goes out most significant bit first, starting from bit 7 of the written word. A word of N bits therefore sends bits 7 down to 8-N.
- R5: sda_o changes only on a clock edge where scl_o is low both before and after that edge.
- R6: Each SCL high phase and each SCL low phase lasts E system clocks, where E is div_cfg, or 2 if div_cfg is below 2. The divider value is taken when the data write is accepted.
- R7: With acknowledge enabled, one extra SCL pulse follows the data bits with sda_o at 1. last_rx_bit_o takes the level of sda_i at the edge where SCL rises for that pulse.
- R8: With acknowledge disabled, no extra pulse is made and last_rx_bit_o keeps its previous value.
- R9: At the end of a word, pending_o goes to 0 and irq_o to 1 on the same edge. scl_o then stays 0 until the next accepted data write.
- R10: A data write while pending_o is 1 is ignored: the word on the bus does not change. overrun_o is set and stays set until the next accepted data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_wr | input | 1 | One-cycle strobe that writes the transmit word |
| data_in | input | DATA_W | Transmit word |
| ctrl_wr | input | 1 | One-cycle strobe that writes the control register |
| ctrl_len | input | CNT_W | Word length code (0 means DATA_W bits) |
| ctrl_ack_en | input | 1 | 1: add an acknowledge clock after the data bits |
| div_cfg | input | DIV_W | SCL half-period in system clocks (minimum 2) |
| sda_i | input | 1 | Sensed SDA line level |
| scl_o | output | 1 | SCL drive (1 releases the line high) |
| sda_o | output | 1 | SDA drive (1 releases the line) |
| irq_o | output | 1 | Transfer-complete interrupt, cleared by an accepted data write |
| pending_o | output | 1 | Word in progress |
| master_o | output | 1 | Master status, always 1 |
| xmit_o | output | 1 | Transmit status, always 1 |
| last_rx_bit_o | output | 1 | Acknowledge level captured from the receiver |
| overrun_o | output | 1 | A data write was dropped while a word was pending |

## Verification
The bench sweeps every length code, with the acknowledge clock both on and off, over three divider settings: one below the minimum, the minimum, and one above it. Each combination uses several data patterns, and each pattern changes the bit order that reaches the bus. The swept lengths separate a wrong length decode from a wrong bit position. The divider settings separate clamping from plain counting. The acknowledge level alternates from word to word, so a capture that is skipped or mis-timed shows up as a stale last-received bit. Extra writes made in the middle of a word show whether they corrupt the shift or fail to flag overrun.

// File: rtl/i2ce_pkg.sv
// Package: shared phase encoding and length decode for the word engine.
// Assumes DATA_W is a power of two so that a length code of 0 means full width.
package i2ce_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    // Decodes a length code: zero stands for the full word width.
    function automatic int unsigned word_len(input int unsigned code, input int unsigned full);
        return (code == 0) ? full : code;
    endfunction

endpackage

// File: rtl/i2ce_phase_timer.sv
// Phase timer: produces SCL low/high phases of equal length from a divider.
// Assumes the divider is stable during the write strobe; latches it at start.
module i2ce_phase_timer
    import i2ce_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] div_cfg,
    input  logic             last_bit,
    output logic             scl,
    output logic             low_first,
    output logic             rise,
    output logic             bit_end,
    output logic             done
);
    localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

    phase_e           phase;
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_eff;

    // Clamp the divider to its minimum.
    always_comb begin
        div_eff = (div_cfg < DIV_MIN) ? DIV_MIN : div_cfg;
    end

    // Step the phase state and the half-period counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            div_q <= DIV_MIN;
        end else if (start) begin
            phase <= PH_LOW;
            cnt   <= div_eff - 1'b1;
            div_q <= div_eff;
        end else begin
            unique case (phase)
                PH_LOW: begin
                    if (cnt == '0) begin
                        phase <= PH_HIGH;
                        cnt   <= div_q - 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (cnt == '0) begin
                        if (last_bit) begin
                            phase <= PH_IDLE;
                        end else begin
                            phase <= PH_LOW;
                            cnt   <= div_q - 1'b1;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                end
            endcase
        end
    end

    // Decode the phase events used by the shifter and the status logic.
    always_comb begin
        scl       = (phase == PH_HIGH);
        low_first = (phase == PH_LOW) && (cnt == div_q - 1'b1);
        rise      = (phase == PH_LOW) && (cnt == '0);
        bit_end   = (phase == PH_HIGH) && (cnt == '0);
        done      = bit_end && last_bit;
    end

endmodule

// File: rtl/i2ce_shifter.sv
// Shifter: holds the word, counts bit slots and drives SDA in each low phase.
// Assumes start, low_first, rise and bit_end come from the phase timer.
module i2ce_shifter
    import i2ce_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] word,
    input  logic [CNT_W-1:0]  len_code,
    input  logic              ack_en,
    input  logic              low_first,
    input  logic              rise,
    input  logic              bit_end,
    input  logic              sda_i,
    output logic              sda_o,
    output logic              last_bit,
    output logic              ack_stb,
    output logic              ack_lvl
);
    localparam int IDX_W = CNT_W + 1;

    logic [DATA_W-1:0] shreg;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  nbits;
    logic              ack_q;
    logic [IDX_W-1:0]  total;
    logic              in_ack;

    // Slot bookkeeping: the total number of slots and whether this one is the acknowledge slot.
    always_comb begin
        total    = nbits + IDX_W'(ack_q);
        in_ack   = ack_q && (idx == nbits);
        last_bit = (idx == total - 1'b1);
        ack_stb  = rise && in_ack;
        ack_lvl  = sda_i;
    end

    // Load the word at start and shift once per completed slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            idx   <= '0;
            nbits <= IDX_W'(DATA_W);
            ack_q <= 1'b0;
        end else if (start) begin
            shreg <= word;
            idx   <= '0;
            nbits <= IDX_W'(word_len(int'(len_code), DATA_W));
            ack_q <= ack_en;
        end else if (bit_end) begin
            shreg <= {shreg[DATA_W-2:0], 1'b0};
            idx   <= idx + 1'b1;
        end
    end

    // Drive SDA one clock into each low phase; release it in the acknowledge slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_o <= 1'b1;
        end else if (low_first) begin
            sda_o <= in_ack ? 1'b1 : shreg[DATA_W-1];
        end
    end

endmodule

// File: rtl/i2ce_ctrl_regs.sv
// Control and status registers: length/acknowledge setup, pending, interrupt,
// overrun and last-received bit. Assumes strobes last one clock.
module i2ce_ctrl_regs #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_wr,
    input  logic             ctrl_wr,
    input  logic [CNT_W-1:0] ctrl_len,
    input  logic             ctrl_ack_en,
    input  logic             done,
    input  logic             ack_stb,
    input  logic             ack_lvl,
    output logic             start,
    output logic [CNT_W-1:0] len_q,
    output logic             ack_en_q,
    output logic             pending,
    output logic             irq,
    output logic             overrun,
    output logic             lrb
);
    // Accept a data write only while no word is pending.
    always_comb begin
        start = data_wr && !pending;
    end

    // Control register for the next word's length and acknowledge setting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q    <= '0;
            ack_en_q <= 1'b1;
        end else if (ctrl_wr) begin
            len_q    <= ctrl_len;
            ack_en_q <= ctrl_ack_en;
        end
    end

    // Pending flag and completion interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            irq     <= 1'b0;
        end else if (start) begin
            pending <= 1'b1;
            irq     <= 1'b0;
        end else if (done) begin
            pending <= 1'b0;
            irq     <= 1'b1;
        end
    end

    // Overrun flag: set by a dropped write, cleared by an accepted one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (data_wr) begin
            overrun <= pending;
        end
    end

    // Capture the receiver's acknowledge level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lrb <= 1'b0;
        end else if (ack_stb) begin
            lrb <= ack_lvl;
        end
    end

endmodule

// File: rtl/i2c_tx_word_engine.sv
// Top: master-transmit data-phase engine. Connects the registers, phase timer
// and shifter. Assumes a start condition has already left SCL low.
module i2c_tx_word_engine #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8,
    parameter int CNT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_in,
    input  logic              ctrl_wr,
    input  logic [CNT_W-1:0]  ctrl_len,
    input  logic              ctrl_ack_en,
    input  logic [DIV_W-1:0]  div_cfg,
    input  logic              sda_i,
    output logic              scl_o,
    output logic              sda_o,
    output logic              irq_o,
    output logic              pending_o,
    output logic              master_o,
    output logic              xmit_o,
    output logic              last_rx_bit_o,
    output logic              overrun_o
);
    logic             start;
    logic [CNT_W-1:0] len_q;
    logic             ack_en_q;
    logic             low_first;
    logic             rise;
    logic             bit_end;
    logic             done;
    logic             last_bit;
    logic             ack_stb;
    logic             ack_lvl;

    i2ce_ctrl_regs #(.CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .ctrl_wr(ctrl_wr),
        .ctrl_len(ctrl_len), .ctrl_ack_en(ctrl_ack_en), .done(done),
        .ack_stb(ack_stb), .ack_lvl(ack_lvl), .start(start), .len_q(len_q),
        .ack_en_q(ack_en_q), .pending(pending_o), .irq(irq_o),
        .overrun(overrun_o), .lrb(last_rx_bit_o)
    );

    i2ce_phase_timer #(.DIV_W(DIV_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .start(start), .div_cfg(div_cfg),
        .last_bit(last_bit), .scl(scl_o), .low_first(low_first),
        .rise(rise), .bit_end(bit_end), .done(done)
    );

    i2ce_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) shift_i (
        .clk(clk), .rst_n(rst_n), .start(start), .word(data_in),
        .len_code(len_q), .ack_en(ack_en_q), .low_first(low_first),
        .rise(rise), .bit_end(bit_end), .sda_i(sda_i), .sda_o(sda_o),
        .last_bit(last_bit), .ack_stb(ack_stb), .ack_lvl(ack_lvl)
    );

    // Fixed role status: this engine only ever acts as master transmitter.
    always_comb begin
        master_o = 1'b1;
        xmit_o   = 1'b1;
    end

endmodule

// File: rtl/i2ce_checker.sv
// Checker: temporal properties of the word engine, bound to the top module.
module i2ce_checker (
    input logic clk,
    input logic rst_n,
    input logic data_wr,
    input logic scl_o,
    input logic sda_o,
    input logic irq_o,
    input logic pending_o,
    input logic overrun_o,
    input logic last_rx_bit_o
);
    AST_SDA_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_o) |-> (!scl_o && !$past(scl_o))); // R5

    AST_ACCEPT_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !pending_o) |=> (pending_o && !irq_o && !overrun_o)); // R2

    AST_DROPPED_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && pending_o) |=> overrun_o); // R10

    AST_IRQ_EXCLUDES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !pending_o); // R9

    AST_IDLE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !pending_o |-> !scl_o); // R9

    AST_IDLE_LRB_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pending_o |=> $stable(last_rx_bit_o)); // R8
endmodule

bind i2c_tx_word_engine i2ce_checker chk_i (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .scl_o(scl_o),
    .sda_o(sda_o), .irq_o(irq_o), .pending_o(pending_o),
    .overrun_o(overrun_o), .last_rx_bit_o(last_rx_bit_o)
);

// File: tb/i2c_tx_word_engine_tb_top.sv
module i2c_tx_word_engine_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_wr = 1'b0;
    logic [7:0] data_in = '0;
    logic       ctrl_wr = 1'b0;
    logic [2:0] ctrl_len = '0;
    logic       ctrl_ack_en = 1'b0;
    logic [7:0] div_cfg = 8'd2;
    logic       sda_i = 1'b1;
    logic       scl_o, sda_o, irq_o, pending_o, master_o, xmit_o, last_rx_bit_o, overrun_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    i2c_tx_word_engine dut_i (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_in(data_in),
        .ctrl_wr(ctrl_wr), .ctrl_len(ctrl_len), .ctrl_ack_en(ctrl_ack_en),
        .div_cfg(div_cfg), .sda_i(sda_i), .scl_o(scl_o), .sda_o(sda_o),
        .irq_o(irq_o), .pending_o(pending_o), .master_o(master_o),
        .xmit_o(xmit_o), .last_rx_bit_o(last_rx_bit_o), .overrun_o(overrun_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sends one word and compares the bus waveform with the expected one.
    task automatic run_word(input logic [7:0] w, input logic [2:0] bc, input bit ack,
                            input logic [7:0] dv, input bit ack_lvl, input bit intrude);
        int nb, ediv, pulses, hi_len, lo_len, cyc;
        bit prev_scl, prev_sda, timing_ok, sda_ok, ack_sda_ok;
        logic [15:0] cap;
        logic [7:0] exp_bits, got_bits;
        bit prev_lrb;
        nb   = (bc == 0) ? 8 : int'(bc);
        ediv = (dv < 2) ? 2 : int'(dv);
        @(negedge clk);
        ctrl_wr = 1'b1; ctrl_len = bc; ctrl_ack_en = ack; div_cfg = dv; sda_i = ack_lvl;
        @(negedge clk);
        ctrl_wr = 1'b0;
        prev_lrb = last_rx_bit_o;
        data_in = w; data_wr = 1'b1;
        @(negedge clk);
        data_wr = 1'b0;
        check(pending_o && !irq_o && (intrude || !overrun_o), "R2", {pending_o, irq_o, overrun_o}, 4);
        pulses = 0; hi_len = 0; lo_len = 1; cyc = 0; cap = '0;
        prev_scl = scl_o; prev_sda = sda_o; timing_ok = 1'b1; sda_ok = 1'b1; ack_sda_ok = 1'b1;
        while (!irq_o && cyc < 4000) begin
            if (intrude && cyc == 4) begin data_in = ~w; data_wr = 1'b1; end
            if (intrude && cyc == 5) data_wr = 1'b0;
            @(negedge clk);
            cyc++;
            if (sda_o != prev_sda && (scl_o || prev_scl)) sda_ok = 1'b0;
            if (scl_o && !prev_scl) begin
                if (lo_len != ediv) timing_ok = 1'b0;
                if (pulses < 16) cap[pulses] = sda_o;
                if (pulses == nb && !sda_o) ack_sda_ok = 1'b0;
                pulses++; hi_len = 1;
            end else if (scl_o) begin
                hi_len++;
            end else if (prev_scl) begin
                if (hi_len != ediv) timing_ok = 1'b0;
                lo_len = 1;
            end else begin
                lo_len++;
            end
            prev_scl = scl_o; prev_sda = sda_o;
        end
        check(cyc < 4000, "R9 completion", cyc, 0);
        exp_bits = '0; got_bits = '0;
        for (int i = 0; i < nb; i++) begin
            exp_bits[i] = w[7-i];
            got_bits[i] = cap[i];
        end
        check(pulses == nb + int'(ack), ack ? "R3 R7 pulses" : "R3 R8 pulses", pulses, nb + int'(ack));
        check(got_bits == exp_bits, intrude ? "R4 R10 data" : "R4 data", got_bits, exp_bits);
        check(sda_ok, "R5 sda stable while scl high", 0, 1);
        check(timing_ok, "R6 phase length", hi_len, ediv);
        if (ack) begin
            check(ack_sda_ok, "R7 sda released on ack", 0, 1);
            check(last_rx_bit_o == ack_lvl, "R7 lrb", last_rx_bit_o, ack_lvl);
        end else begin
            check(last_rx_bit_o == prev_lrb, "R8 lrb held", last_rx_bit_o, prev_lrb);
        end
        check(!pending_o && irq_o && !scl_o, "R9 end state", {pending_o, irq_o, scl_o}, 2);
        if (intrude) check(overrun_o == 1'b1, "R10 overrun", overrun_o, 1);
        repeat (5) @(negedge clk);
        check(!scl_o && irq_o && !pending_o, "R9 scl held low", scl_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!scl_o && sda_o && !pending_o && !irq_o && !overrun_o && !last_rx_bit_o
              && master_o && xmit_o, "R1 reset",
              {scl_o, sda_o, pending_o, irq_o, overrun_o, last_rx_bit_o, master_o, xmit_o}, 8'b0100_0011);
        for (int d = 0; d < 3; d++) begin
            for (int b = 0; b < 8; b++) begin
                for (int a = 0; a < 2; a++) begin
                    for (int k = 0; k < 4; k++) begin
                        logic [7:0] pat;
                        logic [7:0] dvv;
                        pat = 8'hA5 ^ 8'(k * 8'h37) ^ 8'(b << 4);
                        dvv = (d == 0) ? 8'd0 : (d == 1) ? 8'd2 : 8'd3;
                        run_word(pat, 3'(b), a[0], dvv, k[0] ^ a[0] ^ b[0], 1'b0);
                    end
                end
            end
        end
        run_word(8'hC3, 3'd0, 1'b1, 8'd2, 1'b0, 1'b1);
        run_word(8'h5A, 3'd5, 1'b0, 8'd4, 1'b1, 1'b1);
        run_word(8'h96, 3'd0, 1'b1, 8'd2, 1'b1, 1'b0);
        check(!overrun_o, "R10 overrun cleared by accepted write", overrun_o, 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule